// File: doc/BRIEF.md
# Double-Column End-of-Column Hit Buffer

This block is the periphery logic for one double column of a pixel readout chip. The pixel cells keep nothing locally. Every accepted hit, made of a row address, a column-pair bit and a digitized amplitude, goes straight into a shared hit store at the foot of the column. The first accepted hit of a bunch crossing also opens an entry in a timestamp store. That entry records the crossing counter value and how many hits belong to the crossing. Each stored hit carries the index of its timestamp entry.

A level-1 trigger asks for the crossing that is exactly `latency` crossings old. All arithmetic on the 8-bit crossing counter is modulo 256. When the oldest timestamp entry has that age, its hits move one per clock into a readout FIFO, tagged with their crossing value. The timestamp entry is then released. An oldest entry that grows older than the latency without a trigger is retired, and all its hits are freed in the same clock.

While any of the three stores is full, the block raises busy. A hit offered during busy is lost and counted. The usual latency is 128 crossings, which is 3.2 us at 25 ns per crossing. The crossing boundary comes from an external strobe, so one crossing may span several clocks.

Top module: `dcol_hit_buffer`

## Requirements
- R1: After synchronous reset, busy is low, ro_valid is low, lost_count is 0 and bx_now is 0.
- R2: bx_now advances by one, modulo 256, at each clock where bx_strobe is high, and holds otherwise.
- R3: A hit accepted in a clock is stamped with the bx_now value of that clock. This includes a clock where bx_strobe is high. All accepted hits of one crossing share one timestamp entry.
- R4: When trig is high and the oldest timestamp entry has age (bx_now minus its stamp, modulo 256) equal to latency, that entry's hits enter the readout FIFO one per clock, oldest first. Each carries ro_ts equal to its crossing stamp. The entry is released after its last hit moves.
- R5: When the oldest timestamp entry has age greater than latency and is not being transferred, it is retired together with all its hits in one clock. Those hits never appear at the readout port.
- R6: A trigger has no effect while a transfer is in progress, or when the oldest entry's age differs from latency.
- R7: busy is high exactly when the hit store holds 80 entries, the timestamp store holds 24 entries, or the readout FIFO holds 80 entries (default depths).
- R8: A hit offered while busy is high is discarded. lost_count increments by one for each such hit and saturates at its maximum.
- R9: ro_valid is high whenever the readout FIFO is non-empty. The head entry (ro_row, ro_col, ro_amp, ro_ts) stays unchanged until a clock with ro_pop high.
- R10: While the readout FIFO is full, the transfer of triggered hits stalls without losing or reordering any hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bx_strobe | input | 1 | High in the last clock of a bunch crossing |
| hit_valid | input | 1 | A pixel hit is offered this clock |
| hit_row | input | 7 | Row address of the hit |
| hit_col | input | 1 | Column of the pair that fired |
| hit_amp | input | 8 | Digitized amplitude |
| latency | input | 8 | Trigger latency in crossings |
| trig | input | 1 | Level-1 trigger request |
| ro_pop | input | 1 | Consumer takes the readout head this clock |
| busy | output | 1 | A store is full; new hits are refused |
| lost_count | output | 16 | Saturating count of refused hits |
| bx_now | output | 8 | Current crossing counter |
| ro_valid | output | 1 | Readout FIFO holds an entry |
| ro_row | output | 7 | Row of the readout head |
| ro_col | output | 1 | Column bit of the readout head |
| ro_amp | output | 8 | Amplitude of the readout head |
| ro_ts | output | 8 | Crossing stamp of the readout head |

## Verification
The assertions take for granted that latency is at least 1. With that, a trigger can never match the crossing that is still collecting hits, and an entry still taking hits is never the one retired. The stimulus programs latencies of 3, 5 and 128 and keeps them fixed across each run segment. It drives every input just after the falling edge and changes latency only while no crossing is pending.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

    localparam int ROW_W = 7;
    localparam int AMP_W = 8;
    localparam int BX_W  = 8;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic             col;
        logic [AMP_W-1:0] amp;
    } hit_t;

    typedef struct packed {
        hit_t            hit;
        logic [BX_W-1:0] ts;
    } ro_t;

    // advance a ring index by n places, n never exceeding the depth
    function automatic int ring_add(input int a, input int n, input int d);
        int s;
        s = a + n;
        if (s >= d) s = s - d;
        return s;
    endfunction

    function automatic logic [BX_W-1:0] bx_age(input logic [BX_W-1:0] now_v,
                                                input logic [BX_W-1:0] then_v);
        return now_v - then_v;
    endfunction

endpackage

// File: rtl/dcb_ring.sv
module dcb_ring
    import dcb_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic [CW-1:0] pop_n,
    output logic [W-1:0]  rdata,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [IW-1:0] head;
    logic [IW-1:0] tail;
    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (push) mem[tail] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= IW'(ring_add(int'(tail), 1, DEPTH));
            head  <= IW'(ring_add(int'(head), int'(pop_n), DEPTH));
            count <= count + CW'(push) - pop_n;
        end
    end

    assign rdata = mem[head];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

endmodule

// File: rtl/dcb_ts_store.sv
module dcb_ts_store
    import dcb_pkg::*;
#(
    parameter int DEPTH = 24,
    parameter int CNTW  = 7,
    parameter int IW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic [BX_W-1:0] push_ts,
    input  logic            bump,
    input  logic            pop,
    input  logic [IW-1:0]   rd_idx,
    output logic [BX_W-1:0] head_ts,
    output logic [CNTW-1:0] head_cnt,
    output logic [BX_W-1:0] rd_ts,
    output logic [IW-1:0]   cur_idx,
    output logic            full,
    output logic            empty
);

    logic [BX_W-1:0] ts_mem  [DEPTH];
    logic [CNTW-1:0] cnt_mem [DEPTH];
    logic [IW-1:0]   head;
    logic [IW-1:0]   tail;
    logic [IW-1:0]   last;
    logic [CW-1:0]   count;

    assign last = (tail == '0) ? IW'(DEPTH - 1) : tail - 1'b1;

    // push and bump never coincide: a bump targets the open entry
    always_ff @(posedge clk) begin
        if (push) begin
            ts_mem[tail]  <= push_ts;
            cnt_mem[tail] <= CNTW'(1);
        end
        if (bump) cnt_mem[last] <= cnt_mem[last] + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= IW'(ring_add(int'(tail), 1, DEPTH));
            if (pop)  head <= IW'(ring_add(int'(head), 1, DEPTH));
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign head_ts  = ts_mem[head];
    assign head_cnt = cnt_mem[head];
    assign rd_ts    = ts_mem[rd_idx];
    assign cur_idx  = push ? tail : last;
    assign full     = (count == CW'(DEPTH));
    assign empty    = (count == '0);

endmodule

// File: rtl/dcol_hit_buffer.sv
module dcol_hit_buffer
    import dcb_pkg::*;
#(
    parameter int HIT_DEPTH = 80,
    parameter int TS_DEPTH  = 24,
    parameter int RO_DEPTH  = 80,
    parameter int LOST_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bx_strobe,
    input  logic              hit_valid,
    input  logic [ROW_W-1:0]  hit_row,
    input  logic              hit_col,
    input  logic [AMP_W-1:0]  hit_amp,
    input  logic [BX_W-1:0]   latency,
    input  logic              trig,
    input  logic              ro_pop,
    output logic              busy,
    output logic [LOST_W-1:0] lost_count,
    output logic [BX_W-1:0]   bx_now,
    output logic              ro_valid,
    output logic [ROW_W-1:0]  ro_row,
    output logic              ro_col,
    output logic [AMP_W-1:0]  ro_amp,
    output logic [BX_W-1:0]   ro_ts
);

    localparam int TSI_W = $clog2(TS_DEPTH);
    localparam int HCW   = $clog2(HIT_DEPTH + 1);
    localparam int RCW   = $clog2(RO_DEPTH + 1);
    localparam int HE_W  = $bits(hit_t) + TSI_W;
    localparam int RE_W  = $bits(ro_t);

    // store status
    logic hit_full, hit_empty, ts_full, ts_empty, ro_full, ro_empty;

    // hit store datapath
    hit_t             hit_in, hit_head;
    logic [HE_W-1:0]  hit_wr, hit_rd;
    logic [TSI_W-1:0] head_tsidx, cur_tsidx;
    logic [HCW-1:0]   hit_pop_n;

    // timestamp store datapath
    logic [BX_W-1:0] head_ts, link_ts, age;
    logic [HCW-1:0]  head_cnt;

    // readout datapath
    ro_t ro_in, ro_head;

    // control
    logic           hit_acc, ts_push, ts_bump, ts_pop, ts_open;
    logic           head_live, retire, trig_take;
    logic           draining, drain_step, drain_last, ro_pop_eff;
    logic [HCW-1:0] drain_left;

    assign busy    = hit_full | ts_full | ro_full;
    assign hit_acc = hit_valid & ~busy;
    assign ts_push = hit_acc & ~ts_open;
    assign ts_bump = hit_acc & ts_open;

    assign age        = bx_age(bx_now, head_ts);
    assign head_live  = ~ts_empty;
    assign retire     = head_live & ~draining & (age > latency);
    assign trig_take  = trig & head_live & ~draining & (age == latency);
    assign drain_step = draining & ~ro_full & ~hit_empty;
    assign drain_last = drain_step & (drain_left == HCW'(1));
    assign ts_pop     = retire | drain_last;
    assign hit_pop_n  = retire ? head_cnt : HCW'(drain_step);
    assign ro_pop_eff = ro_pop & ~ro_empty;

    assign hit_in     = '{row: hit_row, col: hit_col, amp: hit_amp};
    assign hit_wr     = {hit_in, cur_tsidx};
    assign hit_head   = hit_t'(hit_rd[HE_W-1:TSI_W]);
    assign head_tsidx = hit_rd[TSI_W-1:0];
    assign ro_in      = '{hit: hit_head, ts: link_ts};

    dcb_ring #(.W(HE_W), .DEPTH(HIT_DEPTH)) u_hits (
        .clk   (clk),
        .rst   (rst),
        .push  (hit_acc),
        .wdata (hit_wr),
        .pop_n (hit_pop_n),
        .rdata (hit_rd),
        .full  (hit_full),
        .empty (hit_empty)
    );

    dcb_ts_store #(.DEPTH(TS_DEPTH), .CNTW(HCW)) u_stamps (
        .clk      (clk),
        .rst      (rst),
        .push     (ts_push),
        .push_ts  (bx_now),
        .bump     (ts_bump),
        .pop      (ts_pop),
        .rd_idx   (head_tsidx),
        .head_ts  (head_ts),
        .head_cnt (head_cnt),
        .rd_ts    (link_ts),
        .cur_idx  (cur_tsidx),
        .full     (ts_full),
        .empty    (ts_empty)
    );

    dcb_ring #(.W(RE_W), .DEPTH(RO_DEPTH)) u_readout (
        .clk   (clk),
        .rst   (rst),
        .push  (drain_step),
        .wdata (ro_in),
        .pop_n (RCW'(ro_pop_eff)),
        .rdata (ro_head),
        .full  (ro_full),
        .empty (ro_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bx_now     <= '0;
            ts_open    <= 1'b0;
            lost_count <= '0;
            draining   <= 1'b0;
            drain_left <= '0;
        end else begin
            if (bx_strobe) bx_now <= bx_now + 1'b1;

            if (bx_strobe)    ts_open <= 1'b0;
            else if (ts_push) ts_open <= 1'b1;

            if (hit_valid && busy && (lost_count != '1))
                lost_count <= lost_count + 1'b1;

            if (trig_take) begin
                draining   <= 1'b1;
                drain_left <= head_cnt;
            end else if (drain_last) begin
                draining <= 1'b0;
            end else if (drain_step) begin
                drain_left <= drain_left - 1'b1;
            end
        end
    end

    assign ro_valid = ~ro_empty;
    assign ro_row   = ro_head.hit.row;
    assign ro_col   = ro_head.hit.col;
    assign ro_amp   = ro_head.hit.amp;
    assign ro_ts    = ro_head.ts;

endmodule

// File: rtl/dcb_checker.sv
module dcb_checker
    import dcb_pkg::*;
#(
    parameter int LOST_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bx_strobe,
    input logic [BX_W-1:0]   bx_now,
    input logic              hit_valid,
    input logic              busy,
    input logic [LOST_W-1:0] lost_count,
    input logic              ro_valid,
    input logic              ro_pop,
    input logic [ROW_W-1:0]  ro_row,
    input logic              ro_col,
    input logic [AMP_W-1:0]  ro_amp,
    input logic [BX_W-1:0]   ro_ts,
    input logic              draining,
    input logic [BX_W-1:0]   age,
    input logic [BX_W-1:0]   latency,
    input logic [BX_W-1:0]   link_ts,
    input logic [BX_W-1:0]   head_ts
);

    // R2
    bx_step_chk: assert property (@(posedge clk) disable iff (rst)
        bx_strobe |=> ((bx_now - $past(bx_now)) == BX_W'(1)));

    // R2
    bx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bx_strobe |=> $stable(bx_now));

    // R8
    lost_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (lost_count != $past(lost_count)) |-> $past(hit_valid && busy));

    // R9
    ro_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ro_valid && !ro_pop) |=> (ro_valid && $stable(ro_row) && $stable(ro_col)
                                   && $stable(ro_amp) && $stable(ro_ts)));

    // R4
    trig_age_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(draining) |-> ($past(age) == $past(latency)));

    // R4
    link_chk: assert property (@(posedge clk) disable iff (rst)
        draining |-> (link_ts == head_ts));

endmodule

bind dcol_hit_buffer dcb_checker #(.LOST_W(LOST_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bx_strobe  (bx_strobe),
    .bx_now     (bx_now),
    .hit_valid  (hit_valid),
    .busy       (busy),
    .lost_count (lost_count),
    .ro_valid   (ro_valid),
    .ro_pop     (ro_pop),
    .ro_row     (ro_row),
    .ro_col     (ro_col),
    .ro_amp     (ro_amp),
    .ro_ts      (ro_ts),
    .draining   (draining),
    .age        (age),
    .latency    (latency),
    .link_ts    (link_ts),
    .head_ts    (head_ts)
);

// File: tb/dcol_hit_buffer_test.sv
module dcol_hit_buffer_test;

    localparam int HD = 80;
    localparam int TD = 24;
    localparam int RD = 80;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bx_strobe = 1'b0;
    logic       hit_valid = 1'b0;
    logic [6:0] hit_row = '0;
    logic       hit_col = 1'b0;
    logic [7:0] hit_amp = '0;
    logic [7:0] latency = 8'd3;
    logic       trig = 1'b0;
    logic       ro_pop = 1'b0;
    logic        busy;
    logic [15:0] lost_count;
    logic [7:0]  bx_now;
    logic        ro_valid;
    logic [6:0]  ro_row;
    logic        ro_col;
    logic [7:0]  ro_amp;
    logic [7:0]  ro_ts;

    always #10 clk = ~clk;

    dcol_hit_buffer uut (
        .clk(clk), .rst(rst), .bx_strobe(bx_strobe), .hit_valid(hit_valid),
        .hit_row(hit_row), .hit_col(hit_col), .hit_amp(hit_amp),
        .latency(latency), .trig(trig), .ro_pop(ro_pop),
        .busy(busy), .lost_count(lost_count), .bx_now(bx_now),
        .ro_valid(ro_valid), .ro_row(ro_row), .ro_col(ro_col),
        .ro_amp(ro_amp), .ro_ts(ro_ts)
    );

    typedef struct { int row; int col; int amp; } mh_t;
    typedef struct { int ts; int cnt; } mt_t;
    typedef struct { int row; int col; int amp; int ts; } mr_t;

    mh_t hq[$];
    mt_t tq[$];
    mr_t rq[$];
    mr_t got[$];
    int  m_bx, m_lost, m_left;
    bit  m_open, m_drain;
    int  checks = 0, errors = 0;
    int  busy_seen = 0, ro_seen = 0;
    int  sc = 0;
    bit  cmp_en = 1'b0;
    int  wd = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // behavioural reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            hq.delete(); tq.delete(); rq.delete();
            m_bx = 0; m_lost = 0; m_left = 0; m_open = 0; m_drain = 0;
        end else begin
            bit mbusy, rfull, ret, take, step, lst;
            int age;
            mbusy = (hq.size() == HD) || (tq.size() == TD) || (rq.size() == RD);
            rfull = (rq.size() == RD);
            age   = (tq.size() > 0) ? ((m_bx - tq[0].ts) & 255) : 0;
            ret   = (tq.size() > 0) && !m_drain && (age > int'(latency));
            take  = trig && (tq.size() > 0) && !m_drain && (age == int'(latency));
            step  = m_drain && !rfull && (hq.size() > 0);
            lst   = step && (m_left == 1);
            if (ro_pop && rq.size() > 0) void'(rq.pop_front());
            if (step) begin
                mh_t h;
                h = hq.pop_front();
                rq.push_back('{h.row, h.col, h.amp, tq[0].ts});
                m_left--;
                if (lst) begin void'(tq.pop_front()); m_drain = 0; end
            end
            if (ret) begin
                for (int k = 0; k < tq[0].cnt; k++) void'(hq.pop_front());
                void'(tq.pop_front());
            end
            if (take) begin m_drain = 1; m_left = tq[0].cnt; end
            if (hit_valid) begin
                if (mbusy) begin
                    if (m_lost < 65535) m_lost++;
                end else begin
                    hq.push_back('{int'(hit_row), int'(hit_col), int'(hit_amp)});
                    if (m_open) tq[tq.size()-1].cnt++;
                    else tq.push_back('{m_bx, 1});
                    m_open = 1;
                end
            end
            if (bx_strobe) begin m_bx = (m_bx + 1) & 255; m_open = 0; end
            if (ro_valid && ro_pop) got.push_back('{int'(ro_row), int'(ro_col), int'(ro_amp), int'(ro_ts)});
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!rst && cmp_en) begin
            bit eb;
            eb = (hq.size() == HD) || (tq.size() == TD) || (rq.size() == RD);
            if (eb) busy_seen++;
            chk(busy === eb, "R7 busy", int'(busy), int'(eb));
            chk(ro_valid === (rq.size() > 0), "R9 ro_valid", int'(ro_valid), rq.size());
            if (ro_valid && rq.size() > 0) begin
                ro_seen++;
                chk(int'(ro_row) == rq[0].row, "R4 R5 R6 R10 ro_row", int'(ro_row), rq[0].row);
                chk(int'(ro_col) == rq[0].col, "R4 R10 ro_col", int'(ro_col), rq[0].col);
                chk(int'(ro_amp) == rq[0].amp, "R4 R10 ro_amp", int'(ro_amp), rq[0].amp);
                chk(int'(ro_ts) == rq[0].ts, "R3 R4 ro_ts", int'(ro_ts), rq[0].ts);
            end
            chk(int'(lost_count) == m_lost, "R8 lost_count", int'(lost_count), m_lost);
            chk(int'(bx_now) == m_bx, "R2 bx_now", int'(bx_now), m_bx);
        end
    end

    task automatic step(input bit hv, input int row, input int amp, input bit tr, input bit pop);
        @(negedge clk);
        hit_valid = hv;
        hit_row   = 7'(row);
        hit_col   = 1'(row);
        hit_amp   = 8'(amp);
        trig      = tr;
        ro_pop    = pop;
        bx_strobe = (sc % 4 == 3);
        sc++;
    endtask

    task automatic run(input int n, input int hit_pct, input int trig_pct, input int pop_pct);
        for (int i = 0; i < n; i++)
            step($urandom_range(99) < hit_pct, $urandom_range(127), $urandom_range(255),
                 $urandom_range(99) < trig_pct, $urandom_range(99) < pop_pct);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(ro_valid == 1'b0, "R1 ro_valid", int'(ro_valid), 0);
        chk(lost_count == 16'd0, "R1 lost_count", int'(lost_count), 0);
        chk(bx_now == 8'd0, "R1 bx_now", int'(bx_now), 0);
        cmp_en = 1'b1;

        // directed: crossing 0 has two hits, crossing 1 one hit, trigger at crossing 3
        latency = 8'd3;
        step(1, 5, 11, 0, 1);
        step(1, 6, 12, 0, 1);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);
        step(1, 7, 13, 0, 1);
        for (int i = 0; i < 7; i++) step(0, 0, 0, 0, 1);
        step(0, 0, 0, 1, 1);
        for (int i = 0; i < 30; i++) step(0, 0, 0, 0, 1);
        chk(got.size() == 2, "R4 R5 triggered hit count", got.size(), 2);
        if (got.size() >= 2) begin
            chk(got[0].row == 5, "R4 first hit row", got[0].row, 5);
            chk(got[1].row == 6, "R4 second hit row", got[1].row, 6);
            chk(got[0].ts == 0, "R3 stamp of triggered crossing", got[0].ts, 0);
            chk(got[1].amp == 12, "R4 second hit amp", got[1].amp, 12);
        end
        // R6: a trigger with no crossing of matching age changes nothing
        step(0, 0, 0, 1, 1);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1);
        chk(ro_valid == 1'b0, "R6 stray trigger", int'(ro_valid), 0);

        latency = 8'd5;
        run(3000, 50, 25, 70);
        // readout fills and stalls, then drains
        run(600, 80, 60, 0);
        run(400, 0, 0, 100);
        // timestamp store fill at the usual latency
        for (int i = 0; i < 80; i++) step(0, 0, 0, 0, 1);
        latency = 8'd128;
        for (int i = 0; i < 800; i++) step(sc % 4 == 0, i, i, 0, 1);
        // hit store fill
        run(200, 100, 0, 100);
        for (int i = 0; i < 700; i++) step(0, 0, 0, 0, 1);

        chk(busy_seen > 0, "R7 busy observed", busy_seen, 1);
        chk(lost_count > 0, "R8 hits lost", int'(lost_count), 1);
        chk(ro_seen > 0, "R10 readout activity", ro_seen, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 200000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 200000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule